// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address for 4 KB pages. It walks a four-level table tree held in memory. The walk starts from a root frame number that is supplied as an input and sampled when a request is accepted. At each level a 9-bit slice of the virtual address selects one 8-byte entry in a 4096-byte table. That entry either names the frame of the next table, or, at the last level, the frame of the page itself.

A client presents a virtual address, an access kind and a user/supervisor flag on a valid/ready request channel. The walker then issues at most four dependent 64-bit entry reads on a memory port. The port has a valid/ready request and response, and only one read is outstanding at a time. The walker answers with either a physical address or a fault. A fault carries the virtual address and a cause. Permission bits are gathered from all four levels and checked once the walk reaches the last level.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready_o`=1, `mem_req_valid_o`=0, `rsp_valid_o`=0.
- R2: The first read of a walk goes to address {root_i, va[47:39], 3'b000}, with `root_i` sampled when the request is accepted.
- R3: Each later read goes to {previous entry bits 51:12, next index, 3'b000}. The indices are va[38:30], va[29:21] and va[20:12] in that order. Entry bits 63:52 and 11:3 have no effect on addressing.
- R4: If bit 0 (present) of the entry read at any level is 0, the walk stops with no further reads. It then answers with `rsp_fault_o`=1, `rsp_cause_o`=0 (not present) and `rsp_va_o` equal to the request address.
- R5: A walk that succeeds makes exactly four reads. It answers with `rsp_fault_o`=0 and `rsp_pa_o` = {last entry bits 51:12, va[11:0]}.
- R6: `req_acc_i` encodes 2'b00 read, 2'b01 write and 2'b10 instruction fetch; 2'b11 acts as a read. A write faults with `rsp_cause_o`=1 (protection) unless bit 1 is set in all four entries.
- R7: A request with `req_user_i`=1 faults with cause 1 unless bit 2 is set in all four entries. For `req_user_i`=0, bit 2 has no effect.
- R8: A fetch faults with cause 1 if bit 63 is set in any entry. For reads and writes, bit 63 has no effect on the outcome.
- R9: On success `rsp_perm_o` = {bit 63 OR over the levels, bit 2 AND over the levels, bit 1 AND over the levels}, in bit positions 2, 1 and 0.
- R10: At most one read is in flight at a time. A read request holds its address until it is accepted. `req_ready_o` is 0 from acceptance until the response is taken.
- R11: The response holds steady while `rsp_ready_i` is 0. After it is taken, the walker returns to idle.
- R12: A not-present entry at any level takes priority over a permission failure, even one already visible at an upper level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| root_i | input | 40 | Frame number of the top-level table |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept |
| req_va_i | input | 48 | Virtual address to translate |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user_i | input | 1 | Access made from user mode |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 52 | Physical byte address of the entry |
| mem_rsp_valid_i | input | 1 | Entry data valid |
| mem_rsp_ready_o | output | 1 | Walker waits for entry data |
| mem_rsp_data_i | input | 64 | Entry contents |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Client takes the result |
| rsp_fault_o | output | 1 | Result is a fault |
| rsp_cause_o | output | 1 | Fault cause: 0 not present, 1 protection |
| rsp_va_o | output | 48 | Virtual address of the request |
| rsp_pa_o | output | 52 | Physical address on success |
| rsp_perm_o | output | 3 | Gathered permissions {xd_any, us_all, rw_all} |

## Verification
The bench places a not-present entry at the top level and at the last level. A walker that checks presence late, or that keeps reading, shows up as a wrong read count or a wrong cause. A write-protect bit cleared at one upper level, combined with a deeper missing entry, catches a walker that ranks protection above presence. The bench also catches one that looks at only the last entry. An execute-disable bit set at an upper level is tested under both fetch and read: a design that ignores the access kind either misses the fault or faults a plain read. Random garbage in the reserved entry bits, together with all-ones and all-zero indices, exposes slicing or base masking that is wrong by even one bit. Each such error appears as a wrong read address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L4, ST_L3, ST_L2, ST_L1, ST_DONE, ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic {
    CAUSE_NP   = 1'b0,
    CAUSE_PROT = 1'b1
  } cause_e;

  typedef struct packed {
    logic xd_any;
    logic us_all;
    logic rw_all;
  } perm_t;

endpackage

// File: rtl/ptw_pte_dec.sv
module ptw_pte_dec #(
  parameter int PTE_W = 64,
  parameter int PA_W  = 52,
  parameter int OFF_W = 12
) (
  input  logic [PTE_W-1:0]      pte_i,
  output logic                  present_o,
  output logic                  rw_o,
  output logic                  us_o,
  output logic                  xd_o,
  output logic [PA_W-OFF_W-1:0] frame_o
);
  assign present_o = pte_i[0];
  assign rw_o      = pte_i[1];
  assign us_o      = pte_i[2];
  assign xd_o      = pte_i[PTE_W-1];
  assign frame_o   = pte_i[PA_W-1:OFF_W];

  // reserved and software bits do not take part in the walk
  logic unused_bits;
  assign unused_bits = ^{pte_i[PTE_W-2:PA_W], pte_i[OFF_W-1:3]};
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W  = 48,
  parameter int PA_W  = 52,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  localparam int LEVELS = (VA_W - OFF_W) / IDX_W,
  localparam int LVL_W  = $clog2(LEVELS)
) (
  input  logic [VA_W-1:0]       va_i,
  input  logic [PA_W-OFF_W-1:0] base_i,
  input  logic [LVL_W-1:0]      lvl_i,
  output logic [PA_W-1:0]       addr_o
);
  localparam int ENT_SH = OFF_W - IDX_W;

  logic [IDX_W-1:0] idx_tbl [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_tbl[g] = va_i[OFF_W + g*IDX_W +: IDX_W];
  end

  logic unused_off;
  assign unused_off = ^va_i[OFF_W-1:0];

  assign addr_o = {base_i, idx_tbl[lvl_i], {ENT_SH{1'b0}}};
endmodule

// File: rtl/ptw_perm_acc.sv
module ptw_perm_acc
  import ptw_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  upd_i,
  input  logic  rw_i,
  input  logic  us_i,
  input  logic  xd_i,
  input  acc_e  acc_i,
  input  logic  user_i,
  output perm_t perm_o,
  output logic  viol_o
);
  perm_t perm_q, merged;

  assign merged.rw_all = perm_q.rw_all & rw_i;
  assign merged.us_all = perm_q.us_all & us_i;
  assign merged.xd_any = perm_q.xd_any | xd_i;

  // violation judged on the set including the entry now arriving
  assign viol_o = (acc_i == ACC_WRITE && !merged.rw_all) ||
                  (user_i && !merged.us_all) ||
                  (acc_i == ACC_FETCH && merged.xd_any);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    perm_q <= '{xd_any: 1'b0, us_all: 1'b1, rw_all: 1'b1};
    else if (clr_i) perm_q <= '{xd_any: 1'b0, us_all: 1'b1, rw_all: 1'b1};
    else if (upd_i) perm_q <= merged;
  end

  assign perm_o = perm_q;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int PA_W  = 52,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  parameter int PTE_W = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PA_W-OFF_W-1:0] root_i,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [VA_W-1:0]       req_va_i,
  input  logic [1:0]            req_acc_i,
  input  logic                  req_user_i,
  output logic                  mem_req_valid_o,
  input  logic                  mem_req_ready_i,
  output logic [PA_W-1:0]       mem_req_addr_o,
  input  logic                  mem_rsp_valid_i,
  output logic                  mem_rsp_ready_o,
  input  logic [PTE_W-1:0]      mem_rsp_data_i,
  output logic                  rsp_valid_o,
  input  logic                  rsp_ready_i,
  output logic                  rsp_fault_o,
  output logic                  rsp_cause_o,
  output logic [VA_W-1:0]       rsp_va_o,
  output logic [PA_W-1:0]       rsp_pa_o,
  output logic [2:0]            rsp_perm_o
);
  localparam int FR_W   = PA_W - OFF_W;
  localparam int LEVELS = (VA_W - OFF_W) / IDX_W;
  localparam int LVL_W  = $clog2(LEVELS);

  walk_state_e state_q, state_d;
  logic [VA_W-1:0] va_q;
  acc_e            acc_q;
  logic            user_q;
  logic [FR_W-1:0] base_q;
  logic            issued_q;
  logic [PA_W-1:0] pa_q;
  cause_e          cause_q;
  logic [LVL_W-1:0] lvl;

  logic walking, last_lvl, accept, mem_hs, ent_hs;
  logic pte_present, pte_rw, pte_us, pte_xd, viol;
  logic [FR_W-1:0] pte_frame;
  perm_t perm;

  always_comb begin
    unique case (state_q)
      ST_L4:   lvl = LVL_W'(3);
      ST_L3:   lvl = LVL_W'(2);
      ST_L2:   lvl = LVL_W'(1);
      default: lvl = LVL_W'(0);
    endcase
  end

  assign walking  = state_q inside {ST_L4, ST_L3, ST_L2, ST_L1};
  assign last_lvl = (state_q == ST_L1);

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = walking && !issued_q;
  assign mem_rsp_ready_o = walking && issued_q;
  assign accept = req_valid_i && req_ready_o;
  assign mem_hs = mem_req_valid_o && mem_req_ready_i;
  assign ent_hs = mem_rsp_valid_i && mem_rsp_ready_o;

  ptw_pte_dec #(.PTE_W(PTE_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_dec (
    .pte_i     (mem_rsp_data_i),
    .present_o (pte_present),
    .rw_o      (pte_rw),
    .us_o      (pte_us),
    .xd_o      (pte_xd),
    .frame_o   (pte_frame)
  );

  ptw_addr_gen #(.VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .va_i   (va_q),
    .base_i (base_q),
    .lvl_i  (lvl),
    .addr_o (mem_req_addr_o)
  );

  ptw_perm_acc u_perm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .upd_i  (ent_hs && pte_present),
    .rw_i   (pte_rw),
    .us_i   (pte_us),
    .xd_i   (pte_xd),
    .acc_i  (acc_q),
    .user_i (user_q),
    .perm_o (perm),
    .viol_o (viol)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_L4;
      ST_L4:   if (ent_hs) state_d = pte_present ? ST_L3 : ST_FAULT;
      ST_L3:   if (ent_hs) state_d = pte_present ? ST_L2 : ST_FAULT;
      ST_L2:   if (ent_hs) state_d = pte_present ? ST_L1 : ST_FAULT;
      ST_L1:   if (ent_hs) state_d = (pte_present && !viol) ? ST_DONE : ST_FAULT;
      ST_DONE, ST_FAULT: if (rsp_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      va_q     <= '0;
      acc_q    <= ACC_READ;
      user_q   <= 1'b0;
      base_q   <= '0;
      issued_q <= 1'b0;
      pa_q     <= '0;
      cause_q  <= CAUSE_NP;
    end else begin
      state_q <= state_d;
      if (accept) begin
        va_q     <= req_va_i;
        acc_q    <= acc_e'(req_acc_i);
        user_q   <= req_user_i;
        base_q   <= root_i;
        issued_q <= 1'b0;
        pa_q     <= '0;
      end
      if (mem_hs) issued_q <= 1'b1;
      if (ent_hs) begin
        issued_q <= 1'b0;
        if (!pte_present) begin
          cause_q <= CAUSE_NP;
        end else begin
          base_q <= pte_frame;
          if (last_lvl) begin
            if (viol) cause_q <= CAUSE_PROT;
            else      pa_q    <= {pte_frame, va_q[OFF_W-1:0]};
          end
        end
      end
    end
  end

  assign rsp_valid_o = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign rsp_fault_o = (state_q == ST_FAULT);
  assign rsp_cause_o = cause_q;
  assign rsp_va_o    = va_q;
  assign rsp_pa_o    = pa_q;
  assign rsp_perm_o  = perm;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int VA_W  = 48,
  parameter int PA_W  = 52,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  parameter int PTE_W = 64
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [PA_W-OFF_W-1:0] root_i,
  input logic                  req_valid_i,
  input logic                  req_ready_o,
  input logic [VA_W-1:0]       req_va_i,
  input logic                  mem_req_valid_o,
  input logic                  mem_req_ready_i,
  input logic [PA_W-1:0]       mem_req_addr_o,
  input logic                  mem_rsp_ready_o,
  input logic                  rsp_valid_o,
  input logic                  rsp_ready_i,
  input logic                  rsp_fault_o,
  input logic                  rsp_cause_o,
  input logic [VA_W-1:0]       rsp_va_o,
  input logic [PA_W-1:0]       rsp_pa_o
);
  localparam int LEVELS = (VA_W - OFF_W) / IDX_W;
  localparam int ENT_SH = OFF_W - IDX_W;
  localparam int CNT_W  = $clog2(LEVELS + 1) + 1;

  logic [CNT_W-1:0]      cnt_q;
  logic [PA_W-OFF_W-1:0] root_q;
  logic [IDX_W-1:0]      top_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      root_q    <= '0;
      top_idx_q <= '0;
    end else if (req_valid_i && req_ready_o) begin
      cnt_q     <= '0;
      root_q    <= root_i;
      top_idx_q <= req_va_i[VA_W-1 -: IDX_W];
    end else if (mem_req_valid_o && mem_req_ready_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_idle_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o && !mem_rsp_ready_o && !rsp_valid_o);

  assert_mem_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  assert_read_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_ready_i |-> cnt_q < CNT_W'(LEVELS));

  assert_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_req_addr_o[ENT_SH-1:0] == '0);

  assert_first_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && cnt_q == '0 |->
      mem_req_addr_o[PA_W-1:ENT_SH] == {root_q, top_idx_q});

  assert_full_walk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o |-> cnt_q == CNT_W'(LEVELS));

  assert_offset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o |-> rsp_pa_o[OFF_W-1:0] == rsp_va_o[OFF_W-1:0]);

  assert_prot_after_walk_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o && rsp_cause_o |-> cnt_q == CNT_W'(LEVELS));

  assert_rsp_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_fault_o) &&
      $stable(rsp_cause_o) && $stable(rsp_pa_o) && $stable(rsp_va_o));
endmodule

bind ptw_walker ptw_walker_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .PTE_W(PTE_W)
) u_chk (.*);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [39:0] root_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [47:0] req_va_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        req_user_i = 1'b0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [51:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic        mem_rsp_ready_o;
  logic [63:0] mem_rsp_data_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic        rsp_fault_o;
  logic        rsp_cause_o;
  logic [47:0] rsp_va_o;
  logic [51:0] rsp_pa_o;
  logic [2:0]  rsp_perm_o;

  always #4 clk_i = ~clk_i;

  ptw_walker uut (.*);

  int nchk = 0;
  int nerr = 0;

  logic [63:0] mem [logic [51:0]];
  logic [51:0] seen_addr [8];
  int          seen_n = 0;

  logic        exp_fault, exp_cause;
  logic [51:0] exp_pa;
  logic [2:0]  exp_perm;
  logic [51:0] exp_addr [4];
  int          exp_n;

  function automatic logic [63:0] rd(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // memory responder: random accept and latency
  logic        have_req = 1'b0;
  logic [51:0] req_addr = '0;
  int          dly = 0;
  initial begin
    forever begin
      @(negedge clk_i);
      if (mem_rsp_valid_i) mem_rsp_valid_i = 1'b0;
      if (have_req) begin
        if (dly == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = rd(req_addr);
          have_req = 1'b0;
        end else dly--;
      end
      mem_req_ready_i = ($urandom % 3) != 0;
      #1;
      if (mem_req_valid_o && mem_req_ready_i) begin
        have_req = 1'b1;
        req_addr = mem_req_addr_o;
        dly = $urandom % 3;
        if (seen_n < 8) seen_addr[seen_n] = mem_req_addr_o;
        seen_n++;
      end
    end
  end

  task automatic model_walk(input logic [47:0] va, input logic [1:0] acc, input logic user);
    logic [39:0] base = root_i;
    logic rw = 1'b1, us = 1'b1, xd = 1'b0;
    logic [63:0] e;
    exp_n = 0; exp_fault = 1'b0; exp_cause = 1'b0; exp_pa = '0;
    for (int l = 3; l >= 0; l--) begin
      exp_addr[exp_n] = {base, va[12 + 9*l +: 9], 3'b000};
      e = rd(exp_addr[exp_n]);
      exp_n++;
      if (!e[0]) begin exp_fault = 1'b1; exp_cause = 1'b0; return; end
      rw &= e[1]; us &= e[2]; xd |= e[63];
      base = e[51:12];
    end
    exp_perm = {xd, us, rw};
    if ((acc == 2'b01 && !rw) || (user && !us) || (acc == 2'b10 && xd)) begin
      exp_fault = 1'b1; exp_cause = 1'b1;
    end else exp_pa = {base, va[11:0]};
  endtask

  task automatic build(input logic [47:0] va, input logic [39:0] root, input int np_lvl,
                       input logic [3:0] rw_m, input logic [3:0] us_m, input logic [3:0] xd_m);
    logic [39:0] base = root;
    logic [63:0] r, e;
    mem.delete();
    root_i = root;
    for (int l = 3; l >= 0; l--) begin
      r = {$urandom, $urandom};
      e = {$urandom, $urandom};    // junk in reserved and software bits
      e[51:12] = r[39:0];
      e[0] = (l != np_lvl);
      e[1] = rw_m[l];
      e[2] = us_m[l];
      e[63] = xd_m[l];
      mem[{base, va[12 + 9*l +: 9], 3'b000}] = e;
      base = r[39:0];
    end
  endtask

  task automatic run(input logic [47:0] va, input logic [1:0] acc, input logic user, input string tag);
    logic f, c, busy_bad;
    logic [51:0] pa;
    int cyc, hold;
    model_walk(va, acc, user);
    seen_n = 0;
    busy_bad = 1'b0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_va_i = va; req_acc_i = acc; req_user_i = user;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    cyc = 0;
    while (!rsp_valid_o && cyc < 2000) begin
      if (req_ready_o) busy_bad = 1'b1;
      @(negedge clk_i);
      cyc++;
    end
    chk("R10", "idle during walk", {63'd0, busy_bad}, 64'd0);
    f = rsp_fault_o; c = rsp_cause_o; pa = rsp_pa_o;
    hold = $urandom % 3;
    repeat (hold) @(negedge clk_i);
    chk("R11", "held result", {rsp_valid_o, rsp_fault_o, rsp_cause_o, rsp_pa_o}, {1'b1, f, c, pa});
    chk(tag, "fault", {63'd0, rsp_fault_o}, {63'd0, exp_fault});
    if (exp_fault) begin
      chk(exp_cause ? tag : "R4", "cause", {63'd0, rsp_cause_o}, {63'd0, exp_cause});
      chk("R4", "fault va", {16'd0, rsp_va_o}, {16'd0, va});
    end else begin
      chk("R5", "pa", {12'd0, rsp_pa_o}, {12'd0, exp_pa});
      chk("R9", "perm", {61'd0, rsp_perm_o}, {61'd0, exp_perm});
    end
    chk(exp_cause && exp_fault ? "R12" : "R4", "read count", 64'(seen_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < seen_n; i++)
      chk(i == 0 ? "R2" : "R3", "read addr", {12'd0, seen_addr[i]}, {12'd0, exp_addr[i]});
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    chk("R11", "back to idle", {62'd0, req_ready_o, rsp_valid_o}, {62'd0, 1'b1, 1'b0});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    nchk++; nerr++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [47:0] va;
    logic [3:0] rw_m, us_m, xd_m;
    int np;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    chk("R1", "reset state", {61'd0, req_ready_o, mem_req_valid_o, rsp_valid_o}, {61'd0, 3'b100});
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "idle after reset", {61'd0, req_ready_o, mem_req_valid_o, rsp_valid_o}, {61'd0, 3'b100});

    // directed corners
    va = 48'h1234_5678_9abc;
    build(va, 40'h00_0000_1000, 4, 4'hf, 4'hf, 4'h0);
    run(va, 2'b01, 1'b1, "R5");                       // all permissions, user write
    build(va, 40'h00_0000_2000, 4, 4'b1011, 4'hf, 4'h0);
    run(va, 2'b01, 1'b0, "R6");                       // rw clear at one upper level
    run(va, 2'b00, 1'b0, "R6");                       // read unaffected
    build(va, 40'h00_0000_3000, 4, 4'hf, 4'h0, 4'h0);
    run(va, 2'b00, 1'b0, "R7");                       // supervisor ignores us
    run(va, 2'b00, 1'b1, "R7");                       // user faults
    build(va, 40'h00_0000_4000, 4, 4'hf, 4'hf, 4'b0100);
    run(va, 2'b10, 1'b0, "R8");                       // fetch with xd at upper level
    run(va, 2'b00, 1'b0, "R8");                       // read ignores xd
    run(va, 2'b11, 1'b0, "R6");                       // encoding 3 acts as read
    build(va, 40'h00_0000_5000, 3, 4'hf, 4'hf, 4'h0);
    run(va, 2'b00, 1'b0, "R4");                       // top level missing
    build(va, 40'h00_0000_6000, 0, 4'hf, 4'hf, 4'h0);
    run(va, 2'b00, 1'b0, "R4");                       // last level missing
    build(va, 40'h00_0000_7000, 1, 4'b0111, 4'hf, 4'h0);
    run(va, 2'b01, 1'b0, "R12");                      // missing wins over rw
    va = 48'hffff_ffff_ffff;
    build(va, 40'hff_ffff_ffff, 4, 4'hf, 4'hf, 4'h0);
    run(va, 2'b00, 1'b1, "R3");
    va = 48'h0;
    build(va, 40'h0, 4, 4'hf, 4'hf, 4'h0);
    run(va, 2'b00, 1'b0, "R3");

    // random walks
    for (int n = 0; n < 300; n++) begin
      va = {$urandom, $urandom};
      np = ($urandom % 5 == 0) ? int'($urandom % 4) : 4;
      for (int b = 0; b < 4; b++) begin
        rw_m[b] = ($urandom % 8) != 0;
        us_m[b] = ($urandom % 8) != 0;
        xd_m[b] = ($urandom % 8) == 0;
      end
      build(va, 40'($urandom), np, rw_m, us_m, xd_m);
      run(va, 2'($urandom), 1'($urandom), "R6");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule